// File: doc/BRIEF.md
# Direct-Mapped Byte Read Cache

This block sits in front of a slow backing memory. A client presents a 12-bit physical byte address. The block returns the byte either from one of its sixteen 4-byte lines or, after a refill, from memory. The cache is direct mapped, so every address has exactly one line it may occupy. A lookup that finds that line valid with the same upper address bits is a hit, and the byte comes back on the next clock.

When the lookup fails, the block stalls. It raises a busy flag and asks memory for the whole aligned 4-byte block. It waits as long as memory needs, then installs the block with its tag. The requested byte is returned, marked as a miss. Requests offered while busy are dropped, so the client must hold off until busy falls.

The memory port is a level-held request with a one-cycle data-valid answer. It may come any number of cycles later.

Top module: `phys_byte_cache`

## Requirements
- R1: The address splits as byte offset = bits [1:0], line index = bits [5:2] and tag = bits [11:6]. Two addresses share a line exactly when bits [5:2] match.
- R2: After reset no line is valid, so the first read of any address is a miss. While reset is held, busy, mem_req and rsp_valid are all low.
- R3: A read accepted while the indexed line is valid with an equal tag gives, one cycle later, a single-cycle rsp_valid with rsp_hit=1. rsp_data is then the stored byte at the offset, where byte k of a block is bits [8k+7:8k].
- R4: A read that misses raises busy and mem_req on the next cycle. mem_addr then equals the request address with bits [1:0] cleared, and mem_req stays high until mem_rvalid is seen.
- R5: mem_addr does not change while mem_req waits for mem_rvalid.
- R6: In the cycle after mem_rvalid is seen with mem_req high, rsp_valid=1, rsp_hit=0 and busy=0. rsp_data is byte k=offset of mem_rdata. The block and its tag are installed, so later reads of that block hit.
- R7: A request offered while busy is high produces no response and installs nothing.
- R8: A miss on a line that already holds another tag replaces it, so the earlier address misses afterwards.
- R9: mem_rvalid arriving while no refill is pending changes no line and produces no response.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request strobe, taken when busy is low |
| req_addr | input | 12 | Physical byte address |
| busy | output | 1 | Refill in progress; requests are dropped |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_hit | output | 1 | Response came from a resident line |
| rsp_data | output | 8 | Returned byte |
| mem_req | output | 1 | Block read request, held until answered |
| mem_addr | output | 12 | Block-aligned address of the refill |
| mem_rvalid | input | 1 | Memory data strobe |
| mem_rdata | input | 32 | Block data, byte k at bits [8k+7:8k] |

## Verification
The bench builds the cache with its default parameters: 12-bit addresses, 4-byte blocks and 16 lines. This geometry is small enough that a pool of three tags over all sixteen indexes produces dense hit, cold-miss and conflict-eviction traffic within a few hundred reads. Memory answers after a random delay of zero to four cycles, so both immediate and delayed fills occur. Dedicated phases drop a request offered during a fill and inject a stray data strobe while the cache is idle.

// File: rtl/pbc_pkg.sv
package pbc_pkg;

    localparam int unsigned PBC_ADDR_W = 12;
    localparam int unsigned PBC_OFF_W  = 2;
    localparam int unsigned PBC_IDX_W  = 4;
    localparam int unsigned PBC_BYTE_W = 8;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_FILL = 1'b1
    } fsm_e;

    // Number of bytes in a block for a given offset width.
    function automatic int unsigned blk_bytes(input int unsigned off_w);
        return 1 << off_w;
    endfunction

endpackage

// File: rtl/pbc_addr_split.sv
module pbc_addr_split #(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned OFF_W  = 2,
    parameter int unsigned IDX_W  = 4,
    localparam int unsigned TAG_W = ADDR_W - OFF_W - IDX_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [OFF_W-1:0]  off,
    output logic [IDX_W-1:0]  idx,
    output logic [TAG_W-1:0]  tag
);
    assign off = addr[OFF_W-1:0];
    assign idx = addr[OFF_W +: IDX_W];
    assign tag = addr[ADDR_W-1 -: TAG_W];
endmodule

// File: rtl/pbc_byte_pick.sv
module pbc_byte_pick #(
    parameter int unsigned OFF_W  = 2,
    parameter int unsigned BYTE_W = 8,
    localparam int unsigned NBYTES = pbc_pkg::blk_bytes(OFF_W),
    localparam int unsigned BLK_W  = NBYTES * BYTE_W
) (
    input  logic [BLK_W-1:0]  block,
    input  logic [OFF_W-1:0]  off,
    output logic [BYTE_W-1:0] byte_out
);
    logic [BYTE_W-1:0] lanes [NBYTES];

    for (genvar k = 0; k < NBYTES; k++) begin : g_lane
        assign lanes[k] = block[k*BYTE_W +: BYTE_W];
    end

    assign byte_out = lanes[off];
endmodule

// File: rtl/pbc_line_store.sv
module pbc_line_store #(
    parameter int unsigned IDX_W = 4,
    parameter int unsigned TAG_W = 6,
    parameter int unsigned BLK_W = 32,
    localparam int unsigned LINES = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic [TAG_W-1:0] rd_tag,
    output logic [BLK_W-1:0] rd_block,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [BLK_W-1:0] wr_block
);
    logic [LINES-1:0] vld_q;
    logic [TAG_W-1:0] tag_q [LINES];
    logic [BLK_W-1:0] dat_q [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic sel;
        assign sel = wr_en && (wr_idx == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                vld_q[g] <= 1'b0;
            end else if (sel) begin
                vld_q[g] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (sel) begin
                tag_q[g] <= wr_tag;
                dat_q[g] <= wr_block;
            end
        end
    end

    assign rd_valid = vld_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];
    assign rd_block = dat_q[rd_idx];
endmodule

// File: rtl/pbc_fill_ctrl.sv
module pbc_fill_ctrl #(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned OFF_W  = 2,
    parameter int unsigned BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              look_hit,
    input  logic [BYTE_W-1:0] hit_byte,
    input  logic              mem_rvalid,
    input  logic [BYTE_W-1:0] fill_byte,
    output logic              busy,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              fill_we,
    output logic [ADDR_W-1:0] pend_addr,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [BYTE_W-1:0] rsp_data
);
    import pbc_pkg::*;

    fsm_e              state_q;
    logic [ADDR_W-1:0] pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            pend_q    <= '0;
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        if (look_hit) begin
                            rsp_valid <= 1'b1;
                            rsp_hit   <= 1'b1;
                            rsp_data  <= hit_byte;
                        end else begin
                            state_q <= ST_FILL;
                            pend_q  <= req_addr;
                        end
                    end
                end
                ST_FILL: begin
                    if (mem_rvalid) begin
                        state_q   <= ST_IDLE;
                        rsp_valid <= 1'b1;
                        rsp_hit   <= 1'b0;
                        rsp_data  <= fill_byte;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy      = (state_q == ST_FILL);
    assign mem_req   = busy;
    assign mem_addr  = {pend_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    assign fill_we   = busy && mem_rvalid;
    assign pend_addr = pend_q;
endmodule

// File: rtl/phys_byte_cache.sv
module phys_byte_cache #(
    parameter int unsigned ADDR_W = pbc_pkg::PBC_ADDR_W,
    parameter int unsigned OFF_W  = pbc_pkg::PBC_OFF_W,
    parameter int unsigned IDX_W  = pbc_pkg::PBC_IDX_W,
    parameter int unsigned BYTE_W = pbc_pkg::PBC_BYTE_W,
    localparam int unsigned TAG_W = ADDR_W - OFF_W - IDX_W,
    localparam int unsigned BLK_W = pbc_pkg::blk_bytes(OFF_W) * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              busy,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [BYTE_W-1:0] rsp_data,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [BLK_W-1:0]  mem_rdata
);
    logic [OFF_W-1:0]  rq_off,  pd_off;
    logic [IDX_W-1:0]  rq_idx,  pd_idx;
    logic [TAG_W-1:0]  rq_tag,  pd_tag;
    logic              ln_valid;
    logic [TAG_W-1:0]  ln_tag;
    logic [BLK_W-1:0]  ln_block;
    logic [BYTE_W-1:0] hit_byte, fill_byte;
    logic              look_hit;
    logic              fill_we;
    logic [ADDR_W-1:0] pend_addr;

    pbc_addr_split #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_split_req (
        .addr(req_addr), .off(rq_off), .idx(rq_idx), .tag(rq_tag)
    );

    pbc_addr_split #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_split_pend (
        .addr(pend_addr), .off(pd_off), .idx(pd_idx), .tag(pd_tag)
    );

    pbc_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .BLK_W(BLK_W)) u_store (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (rq_idx),
        .rd_valid (ln_valid),
        .rd_tag   (ln_tag),
        .rd_block (ln_block),
        .wr_en    (fill_we),
        .wr_idx   (pd_idx),
        .wr_tag   (pd_tag),
        .wr_block (mem_rdata)
    );

    assign look_hit = ln_valid && (ln_tag == rq_tag);

    pbc_byte_pick #(.OFF_W(OFF_W), .BYTE_W(BYTE_W)) u_pick_hit (
        .block(ln_block), .off(rq_off), .byte_out(hit_byte)
    );

    pbc_byte_pick #(.OFF_W(OFF_W), .BYTE_W(BYTE_W)) u_pick_fill (
        .block(mem_rdata), .off(pd_off), .byte_out(fill_byte)
    );

    pbc_fill_ctrl #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .BYTE_W(BYTE_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_addr   (req_addr),
        .look_hit   (look_hit),
        .hit_byte   (hit_byte),
        .mem_rvalid (mem_rvalid),
        .fill_byte  (fill_byte),
        .busy       (busy),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .fill_we    (fill_we),
        .pend_addr  (pend_addr),
        .rsp_valid  (rsp_valid),
        .rsp_hit    (rsp_hit),
        .rsp_data   (rsp_data)
    );
endmodule

// File: rtl/pbc_checker.sv
module pbc_checker #(
    parameter int unsigned ADDR_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              busy,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_rvalid
);
    AST_HIT_FOLLOWS_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_hit) |-> $past(req_valid && !busy)); // R3

    AST_FILL_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr))); // R5

    AST_FILL_ANSWERS: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_rvalid) |=> (rsp_valid && !rsp_hit && !busy)); // R6

    AST_QUIET_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy |-> !rsp_valid); // R7

    AST_STRAY_DATA_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (!mem_req && mem_rvalid) |=> !(rsp_valid && !rsp_hit)); // R9
endmodule

bind phys_byte_cache pbc_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .busy       (busy),
    .rsp_valid  (rsp_valid),
    .rsp_hit    (rsp_hit),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_rvalid (mem_rvalid)
);

// File: tb/phys_byte_cache_test.sv
`timescale 1ns/1ps
module phys_byte_cache_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [11:0] req_addr = '0;
    logic        busy, rsp_valid, rsp_hit, mem_req;
    logic [7:0]  rsp_data;
    logic [11:0] mem_addr;
    logic        mem_rvalid_m = 1'b0;
    logic [31:0] mem_rdata_m = '0;
    logic        stray_rv = 1'b0;
    logic        mem_rvalid;
    logic [31:0] mem_rdata;

    assign mem_rvalid = mem_rvalid_m | stray_rv;
    assign mem_rdata  = stray_rv ? 32'hDEAD_BEEF : mem_rdata_m;

    always #4 clk = ~clk;

    phys_byte_cache uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .busy(busy), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_data(rsp_data),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    int unsigned checks = 0;
    int unsigned fails  = 0;
    int unsigned sent   = 0;
    int unsigned rcvd   = 0;
    bit          done   = 0;
    logic [11:0] exp_fill = '0;

    logic [8:0]  expq [$];      // {hit, data}
    logic        mval [16];
    logic [5:0]  mtag [16];

    function automatic logic [7:0] mem_byte(input logic [11:0] a);
        if (a == 12'h354) return 8'h36;
        return 8'((a * 7) ^ (a >> 3) ^ 12'h05A);
    endfunction

    function automatic logic [31:0] mem_block(input logic [11:0] a);
        logic [11:0] b;
        b = {a[11:2], 2'b00};
        return {mem_byte(b + 12'd3), mem_byte(b + 12'd2), mem_byte(b + 12'd1), mem_byte(b)};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Monitor: pairs each response with the queued expectation (R3 R6 R7 R9).
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && rsp_valid) begin
                rcvd++;
                if (expq.size() == 0) begin
                    check(0, "R7/R9 unexpected response", {rsp_hit, rsp_data}, 0);
                end else begin
                    logic [8:0] e;
                    e = expq.pop_front();
                    check(rsp_hit == e[8], e[8] ? "R3 hit flag" : "R6 hit flag", rsp_hit, e[8]);
                    check(rsp_data == e[7:0], e[8] ? "R3 data" : "R6 data", rsp_data, e[7:0]);
                    if (!e[8]) check(!busy, "R6 busy low", busy, 0);
                end
            end
        end
    end

    // Backing memory with random latency (R4 R5).
    initial begin
        forever begin
            @(negedge clk);
            mem_rvalid_m = 1'b0;
            if (!rst && mem_req) begin
                int lat;
                check(mem_addr == exp_fill, "R4 fill address", mem_addr, exp_fill);
                lat = $urandom_range(0, 4);
                for (int i = 0; i < lat; i++) begin
                    @(negedge clk);
                    check(mem_req && mem_addr == exp_fill, "R5 request held", mem_addr, exp_fill);
                end
                mem_rvalid_m = 1'b1;
                mem_rdata_m  = mem_block(exp_fill);
            end
        end
    end

    task automatic do_read(input logic [11:0] a, input bit inject, input logic [11:0] inj_a);
        logic [3:0] ix;
        logic [5:0] tg;
        bit hit;
        ix  = a[5:2];                 // R1 split
        tg  = a[11:6];
        hit = mval[ix] && mtag[ix] == tg;
        if (!hit) begin
            mval[ix] = 1'b1;
            mtag[ix] = tg;
            exp_fill = {a[11:2], 2'b00};
        end
        expq.push_back({hit, mem_byte(a)});
        sent++;
        req_valid = 1'b1;
        req_addr  = a;
        @(negedge clk);
        req_valid = 1'b0;
        if (!hit) begin
            check(busy && mem_req, "R4 busy after miss", {busy, mem_req}, 3);
            if (inject && busy) begin
                req_valid = 1'b1;     // R7: dropped while busy
                req_addr  = inj_a;
                @(negedge clk);
                req_valid = 1'b0;
            end
        end
        do @(posedge clk); while (rcvd != sent);
        @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin mval[i] = 1'b0; mtag[i] = '0; end
        repeat (3) @(negedge clk);
        check(!busy && !mem_req && !rsp_valid, "R2 reset outputs", {busy, mem_req, rsp_valid}, 0);
        rst = 1'b0;
        @(negedge clk);

        do_read(12'h354, 0, 0);       // R2 cold miss, R6 fill returns 0x36
        do_read(12'h355, 0, 0);       // R3 hit other byte
        do_read(12'h357, 0, 0);
        do_read(12'h354, 0, 0);       // R3 hit 0x36

        do_read(12'h8A0, 0, 0);       // line 8 fill
        do_read(12'h8A3, 0, 0);       // R3
        do_read(12'h9A0, 0, 0);       // R8 conflict on line 8
        do_read(12'h8A0, 0, 0);       // R8 old tag misses again

        do_read(12'h0F1, 1, 12'h100); // R7 injected request dropped
        do_read(12'h100, 0, 0);       // R7 line 0 was not installed: miss

        @(negedge clk);
        stray_rv = 1'b1;              // R9 stray data strobe while idle
        @(negedge clk);
        stray_rv = 1'b0;
        repeat (2) @(negedge clk);
        check(!busy, "R9 no fill started", busy, 0);
        do_read(12'h356, 0, 0);       // R9 line 5 intact
        do_read(12'h101, 0, 0);       // R9 line 0 intact

        for (int n = 0; n < 300; n++) begin   // R1 R3 R6 R8 mixed traffic
            logic [5:0] tp [3];
            logic [11:0] a;
            tp[0] = 6'h0D; tp[1] = 6'h28; tp[2] = 6'h3F;
            a = {tp[$urandom_range(0, 2)], 4'($urandom_range(0, 15)), 2'($urandom_range(0, 3))};
            do_read(a, (n % 7) == 0, a ^ 12'h040);
        end

        repeat (4) @(negedge clk);
        check(expq.size() == 0, "R7 no missing responses", expq.size(), 0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule